// File: doc/BRIEF.md
# Serial Fuse Blow Sequencer

This block drives a chain of scannable soft-fuse latches so that a chosen set of fuses gets programmed, one at a time. A caller presents a bit mask of the fuses to program, a mode bit and a one-cycle start strobe. The block clears the chain by shifting zeros through every position. It then inserts a single 1 and clocks it along until it reaches the lowest selected position. There it raises the blow-control output for a fixed number of cycles while the chain stays still. The same steps repeat for each further selected position, in increasing index order. The analog programming current, the supply switching and the fuse element are handled elsewhere.

Position 0 is the entry of the chain. On every clock where `scan_en` is high, every bit moves up one position and `scan_data` enters position 0. A 1 inserted and then followed by p zero-shifts therefore sits at position p. Mode 0 (rescan) clears the chain again and inserts a fresh 1 before every fuse. Mode 1 (walk) keeps the 1 in the chain and only shifts it forward by the distance to the next target, so the whole mask is served in one pass.

States: IDLE (waits for start), FLUSH (shifts `NUM_FUSES` zeros), INJECT (shifts in the single 1), MOVE (shifts zeros until the 1 reaches the target), BLOW (blow control high, no shifting), FINISH (one-cycle completion). Transitions: IDLE→FLUSH on start with a non-empty mask, IDLE→FINISH on start with an empty mask, FLUSH→INJECT when the flush count is exhausted, INJECT→BLOW when the target is position 0, INJECT→MOVE otherwise, MOVE→BLOW when the 1 arrives at the target, BLOW→FINISH after the pulse when no target is left, BLOW→FLUSH after the pulse in mode 0, BLOW→MOVE after the pulse in mode 1, FINISH→IDLE always.

Top module: `fuse_blow_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `blow`, `scan_en` and `scan_data` are all low.
- R2: A start with a non-empty mask raises `busy` on the next cycle, and the first `NUM_FUSES` shift cycles carry `scan_data` = 0, which clears the whole chain.
- R3: Whenever `blow` is high, the modelled chain holds exactly one 1, at the position being programmed.
- R4: Each blow pulse lasts exactly `PULSE_CYCLES` cycles, and `scan_en` is low for all of it.
- R5: Every position whose mask bit is 1 is programmed exactly once, no position whose mask bit is 0 is programmed, and programming proceeds in increasing index order.
- R6: In mode 0, each fuse at position t costs `NUM_FUSES` + 1 + t + `PULSE_CYCLES` busy cycles: one full clear, one 1 inserted and t moves. A 1 is inserted once per selected fuse.
- R7: In mode 1, a run with k selected fuses and highest selected position tmax takes `NUM_FUSES` + 1 + tmax + k·`PULSE_CYCLES` busy cycles. A 1 is inserted only once.
- R8: A start with an all-zero mask raises `done` on the next cycle and never raises `busy` or `blow`.
- R9: `done` is high for exactly one cycle, in the cycle after the last blow ends. `busy` is low in that cycle.
- R10: `start`, `mask_in` and `mode` have no effect while `busy` is high. The mask and mode captured at start are used for the whole run.
- R11: `scan_data` is high only in a cycle where `scan_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a run; only accepted while idle |
| mode | input | 1 | 0 = rescan before each fuse, 1 = walk a single 1 through one pass |
| mask_in | input | NUM_FUSES | Bit i set selects chain position i for programming |
| scan_data | output | 1 | Serial bit entering chain position 0 |
| scan_en | output | 1 | Chain shifts by one position on this clock |
| blow | output | 1 | Programming strobe for the fuse selected by the chain |
| busy | output | 1 | High from the cycle after start until the last blow ends |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with an 8-position chain and a 3-cycle blow pulse. At that size, both chain ends (positions 0 and 7) and fully populated masks can be reached in a few hundred cycles. A pulse longer than one cycle shows any shifting during the strobe. Each run's busy length is compared with the mode's cycle formula. A shadow chain driven from `scan_en` and `scan_data` records which position holds the 1 at every blow.

// File: rtl/fuse_blow_pkg.sv
package fuse_blow_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FLUSH,
        ST_INJECT,
        ST_MOVE,
        ST_BLOW,
        ST_FINISH
    } blow_state_t;

    localparam logic MODE_RESCAN = 1'b0;
    localparam logic MODE_WALK   = 1'b1;
endpackage

// File: rtl/fuse_pick.sv
// Lowest set mask bit at or above a floor index.
module fuse_pick #(
    parameter int NUM_FUSES = 16,
    parameter int IW        = $clog2(NUM_FUSES)
) (
    input  logic [NUM_FUSES-1:0] sel_mask,
    input  logic [IW:0]          floor_idx,
    output logic                 found,
    output logic [IW-1:0]        pick_idx
);
    always_comb begin
        found    = 1'b0;
        pick_idx = '0;
        for (int i = NUM_FUSES - 1; i >= 0; i--) begin
            if (sel_mask[i] && ((IW+1)'(i) >= floor_idx)) begin
                found    = 1'b1;
                pick_idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/fuse_step_timer.sv
// Loadable down-counter; expired when it reaches zero.
module fuse_step_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/fuse_blow_ctrl.sv
module fuse_blow_ctrl
    import fuse_blow_pkg::*;
#(
    parameter int NUM_FUSES    = 16,
    parameter int PULSE_CYCLES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 mode,
    input  logic [NUM_FUSES-1:0] mask_in,
    output logic                 scan_data,
    output logic                 scan_en,
    output logic                 blow,
    output logic                 busy,
    output logic                 done
);
    localparam int IW   = (NUM_FUSES > 1) ? $clog2(NUM_FUSES) : 1;
    localparam int MAXC = (NUM_FUSES > PULSE_CYCLES) ? NUM_FUSES : PULSE_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] FLUSH_LOAD = CW'(NUM_FUSES - 1);
    localparam logic [CW-1:0] PULSE_LOAD = CW'(PULSE_CYCLES - 1);

    blow_state_t           state, state_nx;
    logic [NUM_FUSES-1:0]  pend_mask;
    logic                  mode_q;
    logic [IW-1:0]         target;
    logic [IW-1:0]         pos;

    logic                  tmr_load;
    logic [CW-1:0]         tmr_val;
    logic                  tmr_expired;

    logic [NUM_FUSES-1:0]  pick_mask;
    logic [IW:0]           pick_floor;
    logic                  pick_found;
    logic [IW-1:0]         pick_idx;

    assign pick_mask  = (state == ST_IDLE) ? mask_in : pend_mask;
    assign pick_floor = (state == ST_IDLE) ? '0 : ({1'b0, target} + 1'b1);

    fuse_pick #(.NUM_FUSES(NUM_FUSES), .IW(IW)) u_pick (
        .sel_mask  (pick_mask),
        .floor_idx (pick_floor),
        .found     (pick_found),
        .pick_idx  (pick_idx)
    );

    fuse_step_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    // next state and timer control
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (mask_in != '0) begin
                        state_nx = ST_FLUSH;
                        tmr_load = 1'b1;
                        tmr_val  = FLUSH_LOAD;
                    end else begin
                        state_nx = ST_FINISH;
                    end
                end
            end
            ST_FLUSH: begin
                if (tmr_expired) state_nx = ST_INJECT;
            end
            ST_INJECT: begin
                if (target == '0) begin
                    state_nx = ST_BLOW;
                    tmr_load = 1'b1;
                    tmr_val  = PULSE_LOAD;
                end else begin
                    state_nx = ST_MOVE;
                end
            end
            ST_MOVE: begin
                if (IW'(pos + 1'b1) == target) begin
                    state_nx = ST_BLOW;
                    tmr_load = 1'b1;
                    tmr_val  = PULSE_LOAD;
                end
            end
            ST_BLOW: begin
                if (tmr_expired) begin
                    if (!pick_found) begin
                        state_nx = ST_FINISH;
                    end else if (mode_q == MODE_WALK) begin
                        state_nx = ST_MOVE;
                    end else begin
                        state_nx = ST_FLUSH;
                        tmr_load = 1'b1;
                        tmr_val  = FLUSH_LOAD;
                    end
                end
            end
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register and run context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            pend_mask <= '0;
            mode_q    <= MODE_RESCAN;
            target    <= '0;
            pos       <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && start) begin
                pend_mask <= mask_in;
                mode_q    <= mode;
                target    <= pick_idx;
            end
            if (state == ST_INJECT) pos <= '0;
            if (state == ST_MOVE)   pos <= IW'(pos + 1'b1);
            if (state == ST_BLOW && tmr_expired && pick_found) target <= pick_idx;
        end
    end

    // Moore outputs
    always_comb begin
        scan_data = 1'b0;
        scan_en   = 1'b0;
        blow      = 1'b0;
        busy      = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_FLUSH:  begin scan_en = 1'b1; busy = 1'b1; end
            ST_INJECT: begin scan_en = 1'b1; scan_data = 1'b1; busy = 1'b1; end
            ST_MOVE:   begin scan_en = 1'b1; busy = 1'b1; end
            ST_BLOW:   begin blow = 1'b1; busy = 1'b1; end
            ST_FINISH: done = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/fuse_blow_ctrl_chk.sv
module fuse_blow_ctrl_chk #(
    parameter int NUM_FUSES    = 16,
    parameter int PULSE_CYCLES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic [NUM_FUSES-1:0] mask_in,
    input logic                 scan_data,
    input logic                 scan_en,
    input logic                 blow,
    input logic                 busy,
    input logic                 done
);
    logic [31:0] blow_run;

    always_ff @(posedge clk) begin
        if (!rst_n) blow_run <= '0;
        else        blow_run <= blow ? blow_run + 1 : '0;
    end

    // R4
    blow_holds_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blow |-> !scan_en);

    // R4
    pulse_not_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blow |-> (blow_run < 32'(PULSE_CYCLES)));

    // R4
    pulse_full_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(blow) |-> (blow_run == 32'(PULSE_CYCLES)));

    // R11
    data_needs_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_data |-> scan_en);

    // R8
    empty_mask_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done && mask_in == '0) |=> (done && !busy));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    // R9
    done_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(busy)) |-> $past(blow));

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done && mask_in != '0) |=> busy);
endmodule

bind fuse_blow_ctrl fuse_blow_ctrl_chk #(
    .NUM_FUSES    (NUM_FUSES),
    .PULSE_CYCLES (PULSE_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mask_in   (mask_in),
    .scan_data (scan_data),
    .scan_en   (scan_en),
    .blow      (blow),
    .busy      (busy),
    .done      (done)
);

// File: tb/fuse_blow_ctrl_test.sv
module fuse_blow_ctrl_test;
    localparam int N = 8;
    localparam int P = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         mode = 1'b0;
    logic [N-1:0] mask_in = '0;
    logic         scan_data, scan_en, blow, busy, done;

    always #10 clk = ~clk;

    fuse_blow_ctrl #(.NUM_FUSES(N), .PULSE_CYCLES(P)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .mask_in(mask_in),
        .scan_data(scan_data), .scan_en(scan_en), .blow(blow), .busy(busy), .done(done)
    );

    int checks = 0;
    int fails  = 0;

    // shadow chain and run log, sampled at negedge
    logic [N-1:0] chain = '0;
    logic [N-1:0] blown = '0;
    logic         prev_blow = 1'b0;
    int           busy_cnt = 0, inject_cnt = 0, pulse_len = 0;
    int           bad_token = 0, bad_order = 0, bad_width = 0, bad_freeze = 0, bad_flush = 0;
    int           last_pos = -1, shift_cnt = 0;

    always @(negedge clk) begin
        if (start && !busy) begin
            blown = '0; busy_cnt = 0; inject_cnt = 0; pulse_len = 0;
            bad_token = 0; bad_order = 0; bad_width = 0; bad_freeze = 0;
            bad_flush = 0; last_pos = -1; shift_cnt = 0;
        end
        if (blow) begin
            if (scan_en) bad_freeze++;
            if (!prev_blow) begin
                if ($countones(chain) != 1) bad_token++;
                for (int i = 0; i < N; i++) begin
                    if (chain[i]) begin
                        if (i <= last_pos) bad_order++;
                        if (blown[i]) bad_order++;
                        last_pos = i;
                    end
                end
                blown = blown | chain;
                pulse_len = 1;
            end else begin
                pulse_len++;
            end
        end else if (prev_blow && pulse_len != P) begin
            bad_width++;
        end
        if (scan_en) begin
            if (shift_cnt < N && scan_data) bad_flush++;
            shift_cnt++;
            if (scan_data) inject_cnt++;
            chain = {chain[N-2:0], scan_data};
        end
        if (busy) busy_cnt++;
        prev_blow = blow;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_busy(input bit md, input logic [N-1:0] m);
        int k = 0, tmax = 0, sum = 0;
        for (int i = 0; i < N; i++) begin
            if (m[i]) begin
                k++; tmax = i; sum += N + 1 + i + P;
            end
        end
        if (k == 0) return 0;
        return md ? (N + 1 + tmax + k * P) : sum;
    endfunction

    task automatic run_case(input bit md, input logic [N-1:0] m, input bit disturb);
        int guard = 0;
        @(posedge clk); #2;
        start = 1'b1; mode = md; mask_in = m;
        @(posedge clk); #2;
        start = 1'b0;
        // R2: busy the cycle after a non-empty start
        if (m != '0) chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        if (disturb) begin
            repeat (4) @(posedge clk);
            #2; start = 1'b1; mode = ~md; mask_in = ~m;
            @(posedge clk); #2; start = 1'b0;
        end
        do begin
            @(negedge clk);
            guard++;
        end while (!done && guard < 2000);
        chk(done == 1'b1, "R9 done reached", int'(done), 1);
        chk(busy == 1'b0, "R9 busy low with done", int'(busy), 0);
        @(negedge clk); #1;
        chk(done == 1'b0, "R9 done one cycle", int'(done), 0);
        chk(blown == m, disturb ? "R10 captured mask used" : "R5 programmed set",
            int'(blown), int'(m));
        chk(bad_order == 0, "R5 increasing order", bad_order, 0);
        chk(bad_token == 0, "R3 single token at blow", bad_token, 0);
        chk(bad_width == 0, "R4 pulse width", bad_width, 0);
        chk(bad_freeze == 0, "R4 no shift during blow", bad_freeze, 0);
        chk(bad_flush == 0, "R2 initial flush zeros", bad_flush, 0);
        if (md) begin
            chk(busy_cnt == exp_busy(md, m), "R7 walk busy cycles", busy_cnt, exp_busy(md, m));
            chk(inject_cnt == ((m != '0) ? 1 : 0), "R7 single insert", inject_cnt,
                (m != '0) ? 1 : 0);
        end else begin
            chk(busy_cnt == exp_busy(md, m), "R6 rescan busy cycles", busy_cnt, exp_busy(md, m));
            chk(inject_cnt == $countones(m), "R6 insert per fuse", inject_cnt, $countones(m));
        end
    endtask

    // {mode, mask}
    localparam logic [N:0] VEC [8] = '{
        {1'b0, 8'b0000_0001},
        {1'b0, 8'b1000_0001},
        {1'b0, 8'b0010_1100},
        {1'b1, 8'b1000_0001},
        {1'b1, 8'b1111_1111},
        {1'b1, 8'b0100_0000},
        {1'b0, 8'b1000_0000},
        {1'b1, 8'b0001_0110}
    };

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1
        chk(!busy && !done && !blow && !scan_en && !scan_data, "R1 reset outputs",
            int'({busy, done, blow, scan_en, scan_data}), 0);
        @(posedge clk); #2; rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !blow && !scan_en, "R1 idle after reset",
            int'({busy, done, blow, scan_en}), 0);

        for (int v = 0; v < 8; v++) run_case(VEC[v][N], VEC[v][N-1:0], 1'b0);

        // R8 empty mask
        run_case(1'b0, '0, 1'b0);
        chk(busy_cnt == 0 && blown == '0, "R8 empty mask no activity", busy_cnt + int'(blown), 0);
        run_case(1'b1, '0, 1'b0);
        chk(busy_cnt == 0 && blown == '0, "R8 empty mask walk mode", busy_cnt + int'(blown), 0);

        // R10 start/mask/mode changes ignored mid-run
        run_case(1'b0, 8'b0000_1010, 1'b1);
        run_case(1'b1, 8'b1010_0001, 1'b1);

        // R11: scan_data idle-low between runs
        @(negedge clk);
        chk(!scan_data && !scan_en, "R11 no data when idle", int'(scan_data), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule